// File: doc/BRIEF.md
# Wishbone byte-stream UART register front end

This block gives a processor the register view of a 16550-style UART on an 8-bit Wishbone slave port. No bits are serialised and no baud clock exists. A byte written to the transmit holding register leaves at once as one word on an outgoing valid/ready stream. Bytes waiting on an incoming valid/ready stream are handed to the processor one at a time through the receive buffer register. The large buffers on both sides sit outside the block, behind the streams.

Because the far side always takes bytes, the line status always reports an idle, empty transmitter. It never reports receive errors. FIFO controls are accepted and do nothing. Line-control settings other than the divisor-latch access bit are stored for read-back only.

A character-timeout interrupt can be enabled. It fires when receive data has waited a set number of clocks without a read of the receive buffer register. Only that read restarts the count. The modem control register accepts only the value that asserts RTS alone, and flags any other value as a bus error.

Top module: `byte_uart_wb`

## Requirements
- R1: Every cycle with wb_stb_i and wb_cyc_i high and no response pending gets exactly one response, wb_ack_o or wb_err_o, in the next cycle. No response appears otherwise, and the two are never high together.
- R2: The register offset is wb_adr_i[2:0], and wb_adr_i[4:3] is ignored. With LCR bit 7 set, offsets 0 and 1 read and write two 8-bit divisor bytes. LCR (offset 3) and the scratch register (offset 7) read back all 8 written bits. A write to offset 2 (FIFO control) changes nothing that can be read.
- R3: A write to offset 0 with LCR bit 7 clear puts the byte on tx_data with tx_valid high in the next cycle. tx_valid stays high with the byte unchanged until a cycle with tx_ready high. A newer write replaces a byte that has not yet been taken.
- R4: The line status register (offset 5) reads 0x60 ORed with rx_valid in bit 0, so the error bits and bit 7 are always 0. The modem status register (offset 6) and the modem control register (offset 4) read 0.
- R5: A read of offset 0 with LCR bit 7 clear returns rx_data and pops it (rx_ready high in that request cycle) when rx_valid is high. With rx_valid low it returns 0 and no byte is taken.
- R6: A timeout counter advances on each clock with rx_valid high, up to TIMEOUT_CLKS, and is cleared only by a receive-buffer read. A new byte arriving does not clear it. Timeout holds when rx_valid is high and the count equals TIMEOUT_CLKS.
- R7: The interrupt identification register (offset 2) reads 0x0C on timeout with IER bit 0 set. Otherwise it reads 0x04 when rx_valid is high with IER bit 0 set. Otherwise it reads 0x02 when the transmit-empty flag is set with IER bit 1 set. Otherwise it reads 0x01.
- R8: The transmit-empty flag is 0 after reset. A transmit-holding write sets it. An IER write (offset 1, LCR bit 7 clear) loads it from data bit 1. A read of the identification register that returns 0x02 clears it.
- R9: irq_o is high exactly when the identification register would read a value other than 0x01.
- R10: A write of 0x02 to the modem control register is acknowledged with no effect. Any other value written there is answered with wb_err_o instead of wb_ack_o, and also has no effect.
- R11: After reset, wb_ack_o, wb_err_o, tx_valid and irq_o are low, and IER, LCR, the divisor bytes and the scratch register are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Wishbone clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_adr_i | input | 5 | Register address, low three bits decoded |
| wb_dat_i | input | 8 | Write data |
| wb_dat_o | output | 8 | Read data, valid with wb_ack_o |
| wb_we_i | input | 1 | Write enable |
| wb_stb_i | input | 1 | Strobe |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_ack_o | output | 1 | Access acknowledge |
| wb_err_o | output | 1 | Access error (unsupported modem control value) |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Outgoing byte present |
| tx_ready | input | 1 | Outgoing byte taken |
| rx_data | input | 8 | Incoming byte |
| rx_valid | input | 1 | Incoming byte present |
| rx_ready | output | 1 | Incoming byte popped by a receive-buffer read |
| irq_o | output | 1 | Interrupt request |

## Verification
Two events can fall in the same cycle: a receive-buffer read and the timeout counter reaching its limit. When they coincide, the clear from the read must win, and the identification register must fall back from 0x0C to 0x04 while data is still pending. The bench provokes the collision by issuing the read after a sweep of waits around TIMEOUT_CLKS. A behavioural model then judges every cycle, covering the counter, the interrupt line and the popped byte. A second overlap, a new transmit write while an untaken byte is held with tx_ready low, is checked by requiring that the newer byte replaces the older one.

// File: rtl/byte_uart_wb.sv
module byte_uart_wb #(
  parameter int TIMEOUT_CLKS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [4:0] wb_adr_i,
  input  logic [7:0] wb_dat_i,
  output logic [7:0] wb_dat_o,
  input  logic       wb_we_i,
  input  logic       wb_stb_i,
  input  logic       wb_cyc_i,
  output logic       wb_ack_o,
  output logic       wb_err_o,
  output logic [7:0] tx_data,
  output logic       tx_valid,
  input  logic       tx_ready,
  input  logic [7:0] rx_data,
  input  logic       rx_valid,
  output logic       rx_ready,
  output logic       irq_o
);
  localparam int CW = $clog2(TIMEOUT_CLKS + 1);
  localparam logic [CW-1:0] TMO = CW'(TIMEOUT_CLKS);
  localparam logic [2:0] OFS_DATA = 3'd0, OFS_IER = 3'd1, OFS_IIR = 3'd2, OFS_LCR = 3'd3,
                         OFS_MCR = 3'd4, OFS_LSR = 3'd5, OFS_MSR = 3'd6, OFS_SCR = 3'd7;
  localparam logic [7:0] MCR_RTS_ONLY = 8'h02;

  logic [3:0]    ier_q;
  logic [7:0]    lcr_q, scr_q, dll_q, dlm_q, rdata;
  logic          thre_q;
  logic [CW-1:0] tmo_cnt;
  logic [3:0]    iid;

  wire [2:0] ofs     = wb_adr_i[2:0];
  wire       unused_adr = &{1'b0, wb_adr_i[4:3]};
  wire       req     = wb_stb_i & wb_cyc_i & ~(wb_ack_o | wb_err_o);
  wire       rd      = req & ~wb_we_i;
  wire       wr      = req & wb_we_i;
  wire       dlab    = lcr_q[7];
  wire       mcr_bad = wr & (ofs == OFS_MCR) & (wb_dat_i != MCR_RTS_ONLY);
  wire       tmo_hit = rx_valid & (tmo_cnt == TMO);
  wire       thr_wr  = wr & (ofs == OFS_DATA) & ~dlab;

  always_comb begin
    if (ier_q[0] & tmo_hit)       iid = 4'hC;
    else if (ier_q[0] & rx_valid) iid = 4'h4;
    else if (ier_q[1] & thre_q)   iid = 4'h2;
    else                          iid = 4'h1;
  end

  assign irq_o    = ~iid[0];
  assign rx_ready = rd & (ofs == OFS_DATA) & ~dlab;

  always_comb begin
    case (ofs)
      OFS_DATA: rdata = dlab ? dll_q : (rx_valid ? rx_data : 8'h00);
      OFS_IER:  rdata = dlab ? dlm_q : {4'h0, ier_q};
      OFS_IIR:  rdata = {4'h0, iid};
      OFS_LCR:  rdata = lcr_q;
      OFS_LSR:  rdata = {1'b0, 2'b11, 4'b0000, rx_valid};
      OFS_SCR:  rdata = scr_q;
      default:  rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_ack_o <= 1'b0;
      wb_err_o <= 1'b0;
      wb_dat_o <= 8'h00;
    end else begin
      wb_ack_o <= req & ~mcr_bad;
      wb_err_o <= mcr_bad;
      if (rd) wb_dat_o <= rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ier_q <= '0;
      lcr_q <= '0;
      scr_q <= '0;
      dll_q <= '0;
      dlm_q <= '0;
    end else if (wr) begin
      case (ofs)
        OFS_DATA: if (dlab) dll_q <= wb_dat_i;
        OFS_IER:  if (dlab) dlm_q <= wb_dat_i; else ier_q <= wb_dat_i[3:0];
        OFS_LCR:  lcr_q <= wb_dat_i;
        OFS_SCR:  scr_q <= wb_dat_i;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= 8'h00;
    end else if (thr_wr) begin
      tx_valid <= 1'b1;
      tx_data  <= wb_dat_i;
    end else if (tx_ready) begin
      tx_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                 thre_q <= 1'b0;
    else if (thr_wr)                         thre_q <= 1'b1;
    else if (wr & (ofs == OFS_IER) & ~dlab)  thre_q <= wb_dat_i[1];
    else if (rd & (ofs == OFS_IIR) & (iid == 4'h2)) thre_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst | rx_ready)                  tmo_cnt <= '0;
    else if (rx_valid & (tmo_cnt != TMO)) tmo_cnt <= tmo_cnt + 1'b1;
  end
endmodule

module byte_uart_wb_chk (
  input logic       clk,
  input logic       rst,
  input logic [4:0] wb_adr_i,
  input logic       wb_we_i,
  input logic       wb_stb_i,
  input logic       wb_cyc_i,
  input logic       wb_ack_o,
  input logic       wb_err_o,
  input logic [7:0] tx_data,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       irq_o,
  input logic [3:0] ier,
  input logic       cnt_zero
);
  p_one_resp_r1: assert property (@(posedge clk) disable iff (rst)
    (wb_stb_i && wb_cyc_i && !wb_ack_o && !wb_err_o) |=> (wb_ack_o != wb_err_o));
  p_no_stray_r1: assert property (@(posedge clk) disable iff (rst)
    !(wb_stb_i && wb_cyc_i && !wb_ack_o && !wb_err_o) |=> !(wb_ack_o || wb_err_o));
  p_tx_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !(wb_stb_i && wb_cyc_i && wb_we_i)) |=> (tx_valid && $stable(tx_data)));
  p_pop_on_read_r5: assert property (@(posedge clk) disable iff (rst)
    rx_ready |-> (wb_stb_i && wb_cyc_i && !wb_we_i && wb_adr_i[2:0] == 3'd0));
  p_cnt_clear_r6: assert property (@(posedge clk) disable iff (rst)
    rx_ready |=> cnt_zero);
  p_irq_rx_r9: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && ier[0]) |-> irq_o);
  p_err_mcr_r10: assert property (@(posedge clk) disable iff (rst)
    wb_err_o |-> ($past(wb_we_i) && $past(wb_adr_i[2:0]) == 3'd4));
endmodule

bind byte_uart_wb byte_uart_wb_chk u_chk (
  .clk(clk), .rst(rst), .wb_adr_i(wb_adr_i), .wb_we_i(wb_we_i), .wb_stb_i(wb_stb_i),
  .wb_cyc_i(wb_cyc_i), .wb_ack_o(wb_ack_o), .wb_err_o(wb_err_o), .tx_data(tx_data),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .irq_o(irq_o), .ier(ier_q), .cnt_zero(tmo_cnt == '0)
);

// File: tb/tb_byte_uart_wb.sv
`timescale 1ns/1ps
module tb_byte_uart_wb;
  localparam int TMO = 16;

  logic clk = 0, rst = 1;
  logic [4:0] adr = 0;
  logic [7:0] wdat = 0, dat_o, tx_data, rx_data = 0;
  logic we = 0, stb = 0, cyc = 0, ack, err, tx_valid, tx_ready = 1, rx_valid = 0, rx_ready, irq;

  always #2 clk = ~clk;

  byte_uart_wb #(.TIMEOUT_CLKS(TMO)) dut (
    .clk(clk), .rst(rst), .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(dat_o),
    .wb_we_i(we), .wb_stb_i(stb), .wb_cyc_i(cyc), .wb_ack_o(ack), .wb_err_o(err),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .irq_o(irq));

  int checks = 0, fails = 0, cycles = 0;
  logic [7:0] rxq[$];

  // behavioural reference state
  bit m_ack, m_err, m_txv, m_thre;
  logic [7:0] m_dat, m_txd, m_lcr, m_scr, m_dll, m_dlm;
  logic [3:0] m_ier;
  int m_cnt;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int m_iid();
    if (m_ier[0] && rx_valid && m_cnt == TMO) return 'hC;
    if (m_ier[0] && rx_valid) return 'h4;
    if (m_ier[1] && m_thre) return 'h2;
    return 'h1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ack = 0; m_err = 0; m_txv = 0; m_thre = 0; m_dat = 0; m_txd = 0;
      m_lcr = 0; m_scr = 0; m_dll = 0; m_dlm = 0; m_ier = 0; m_cnt = 0;
    end else begin
      bit rq, pop, was_txv;
      int id;
      logic [7:0] rv;
      rq = stb && cyc && !m_ack && !m_err;
      id = m_iid();
      pop = rq && !we && adr[2:0] == 0 && !m_lcr[7];
      was_txv = m_txv;
      if (pop) m_cnt = 0; else if (rx_valid && m_cnt < TMO) m_cnt++;
      if (rq && !we) begin
        case (adr[2:0])
          0: rv = m_lcr[7] ? m_dll : (rx_valid ? rx_data : 8'h00);
          1: rv = m_lcr[7] ? m_dlm : {4'h0, m_ier};
          2: rv = 8'(id);
          3: rv = m_lcr;
          5: rv = 8'h60 | 8'(rx_valid);
          7: rv = m_scr;
          default: rv = 0;
        endcase
        m_dat = rv;
        if (adr[2:0] == 2 && id == 2) m_thre = 0;
      end
      m_ack = rq && !(we && adr[2:0] == 4 && wdat != 8'h02);
      m_err = rq && we && adr[2:0] == 4 && wdat != 8'h02;
      m_txv = was_txv && !tx_ready;
      if (rq && we) begin
        case (adr[2:0])
          0: if (m_lcr[7]) m_dll = wdat; else begin m_txv = 1; m_txd = wdat; m_thre = 1; end
          1: if (m_lcr[7]) m_dlm = wdat; else begin m_ier = wdat[3:0]; m_thre = wdat[1]; end
          3: m_lcr = wdat;
          7: m_scr = wdat;
          default: ;
        endcase
      end
      if (pop && rxq.size() > 0) begin
        void'(rxq.pop_front());
        rx_valid <= rxq.size() > 0;
        rx_data  <= rxq.size() > 0 ? rxq[0] : 8'h00;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      bit e_rdy, e_irq;
      e_rdy = stb && cyc && !m_ack && !m_err && !we && adr[2:0] == 0 && !m_lcr[7];
      e_irq = m_iid() != 1;
      chk(ack == m_ack, "R1 ack", ack, m_ack);
      chk(err == m_err, "R10 err", err, m_err);
      chk(dat_o == m_dat, "R2 rdata", dat_o, m_dat);
      chk(tx_valid == m_txv, "R3 tx_valid", tx_valid, m_txv);
      if (m_txv) chk(tx_data == m_txd, "R3 tx_data", tx_data, m_txd);
      chk(rx_ready == e_rdy, "R5 rx_ready", rx_ready, e_rdy);
      chk(irq == e_irq, "R9 irq", irq, e_irq);
    end
  end

  task automatic final_report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog act=%0d exp=0", cycles);
      final_report();
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wb(input bit w, input logic [4:0] a, input logic [7:0] d, output logic [7:0] r);
    tick(1);
    we = w; adr = a; wdat = d; stb = 1; cyc = 1;
    tick(1);
    r = dat_o;
    stb = 0; cyc = 0; we = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    logic [7:0] r;
    wb(1, a, d, r);
  endtask

  task automatic rd_exp(input logic [4:0] a, input logic [7:0] e, input string tag);
    logic [7:0] r;
    wb(0, a, 0, r);
    chk(r == e, tag, r, e);
  endtask

  task automatic push(input logic [7:0] b);
    rxq.push_back(b);
    rx_valid = 1;
    rx_data = rxq[0];
  endtask

  initial begin
    logic [7:0] r;
    tick(3);
    rst = 0;
    tick(1);
    // R11 reset state
    chk(!ack && !err && !tx_valid && !irq, "R11 outputs after reset", {ack, err, tx_valid, irq}, 0);
    rd_exp(5'd5, 8'h60, "R4 LSR idle");
    rd_exp(5'd2, 8'h01, "R7 IIR none");
    rd_exp(5'd3, 8'h00, "R11 LCR reset");
    // R2 decode
    wr(5'd3, 8'h1B);
    rd_exp(5'd3, 8'h1B, "R2 LCR readback");
    wr(5'b11111, 8'hA5);
    rd_exp(5'd7, 8'hA5, "R2 SCR with high address bits");
    wr(5'd3, 8'h83);
    wr(5'd0, 8'h12);
    wr(5'd1, 8'h34);
    rd_exp(5'd0, 8'h12, "R2 divisor low");
    rd_exp(5'd1, 8'h34, "R2 divisor high");
    chk(!tx_valid, "R2 divisor write not sent", tx_valid, 0);
    wr(5'd3, 8'h03);
    rd_exp(5'd1, 8'h00, "R2 IER untouched by divisor");
    // R3 transmit
    wr(5'd0, 8'h41);
    tick(1);
    tx_ready = 0;
    wr(5'd0, 8'h55);
    tick(3);
    chk(tx_valid && tx_data == 8'h55, "R3 held while not ready", tx_data, 8'h55);
    wr(5'd0, 8'h66);
    chk(tx_data == 8'h66, "R3 newer byte replaces", tx_data, 8'h66);
    tx_ready = 1;
    tick(2);
    chk(!tx_valid, "R3 taken", tx_valid, 0);
    // R2/R4/R5 receive, FIFO clear ignored
    push(8'h31);
    tick(1);
    wr(5'd2, 8'h07);
    rd_exp(5'd5, 8'h61, "R4 LSR data ready after FIFO clear");
    rd_exp(5'd0, 8'h31, "R5 RBR pops byte");
    rd_exp(5'd5, 8'h60, "R4 LSR empty");
    rd_exp(5'd0, 8'h00, "R5 RBR empty reads 0");
    // R7/R6 receive interrupts
    wr(5'd1, 8'h01);
    push(8'h77);
    tick(2);
    chk(irq, "R9 irq on data", irq, 1);
    rd_exp(5'd2, 8'h04, "R7 IIR data available");
    tick(TMO + 4);
    rd_exp(5'd2, 8'h0C, "R7 IIR timeout");
    rd_exp(5'd0, 8'h77, "R5 RBR after timeout");
    push(8'h81);
    tick(10);
    push(8'h82);
    tick(8);
    rd_exp(5'd2, 8'h0C, "R6 arrival does not restart count");
    rd_exp(5'd0, 8'h81, "R6 read first");
    rd_exp(5'd2, 8'h04, "R6 read restarts count");
    rd_exp(5'd0, 8'h82, "R5 second byte");
    for (int d = TMO - 3; d <= TMO + 1; d++) begin
      push(8'(8'hC0 + d));
      push(8'hEE);
      tick(d);
      rd_exp(5'd0, 8'(8'hC0 + d), "R6 read near timeout");
      rd_exp(5'd0, 8'hEE, "R5 drain");
    end
    // R8 transmit-empty interrupt
    wr(5'd1, 8'h02);
    tick(1);
    chk(irq, "R8 irq on enable", irq, 1);
    rd_exp(5'd2, 8'h02, "R8 IIR tx empty");
    rd_exp(5'd2, 8'h01, "R8 cleared by IIR read");
    wr(5'd0, 8'h5A);
    tick(1);
    chk(irq, "R8 set by THR write", irq, 1);
    wr(5'd1, 8'h00);
    tick(1);
    chk(!irq, "R8 cleared by IER", irq, 0);
    // R10 modem control
    wb(1, 5'd4, 8'h02, r);
    chk(ack && !err, "R10 RTS-only write acked", {ack, err}, 2);
    tick(1);
    wb(1, 5'd4, 8'h03, r);
    chk(err && !ack, "R10 other value errors", {ack, err}, 1);
    tick(1);
    rd_exp(5'd4, 8'h00, "R10 MCR reads 0");
    rd_exp(5'd6, 8'h00, "R4 MSR reads 0");
    tick(4);
    final_report();
  end
endmodule